// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block turns an asynchronous serial line back into bytes. It is driven by a 16x oversampling tick and a small control word. The control word selects the number of data bits (five to eight), whether a parity bit follows the data, and how that bit is judged: odd, even, or forced to a fixed value. The line is synchronised to the core clock and watched for a falling edge. The candidate start bit is confirmed half a bit later, and each later bit is sampled at its centre. Each finished frame is presented as an 8-bit value with the unused high bits cleared, along with three status flags: parity error, framing error and break.

Finished frames leave through a valid/ready output stage that holds one frame. `out_valid_o` rises when a frame completes and stays high, with its data and flags held steady, until a cycle in which `out_ready_i` is high. The serial line cannot be stalled, so back-pressure cannot hold off the sender. If a new frame completes while the previous one is still held, the new frame replaces it. If a frame completes in the same cycle that the held one is accepted, the new frame is loaded and `out_valid_o` stays high.

Whenever the stop bit is sampled low, the receiver stays idle until the line has gone high again. This means a held-low line cannot produce a stream of phantom frames.

Top module: `frame_rx`

## Requirements
- R1: After reset, `out_valid_o`, `out_data_o`, `par_err_o`, `frm_err_o` and `brk_o` are all 0.
- R2: `wlen_i` selects the number of data bits: 00=5, 01=6, 10=7, 11=8. Data arrives least significant bit first and is sampled at tick 8 of the 16 ticks in each bit. Output bits above the selected length are 0.
- R3: With `par_en_i`=0, no parity bit is expected, the bit after the data is taken as the stop bit, and `par_err_o` is 0.
- R4: With `par_en_i`=1 and `par_force_i`=0, the expected parity bit makes the total count of ones over the data and parity bits odd when `par_even_i`=0, and even when `par_even_i`=1. A mismatch sets `par_err_o` for that frame.
- R5: With `par_en_i`=1 and `par_force_i`=1, the parity bit must be 1 when `par_even_i`=0 and 0 when `par_even_i`=1. Any other value sets `par_err_o`.
- R6: The line is sampled again at the 8th tick after a falling edge. If it is high again, the start is dropped as false and no frame is produced.
- R7: Only the first stop bit is checked. If it is sampled as 0, `frm_err_o` is set for that frame.
- R8: A frame whose data bits, parity bit (if enabled) and stop bit are all 0 sets `brk_o` with `frm_err_o`=1 and data 0. The receiver then starts nothing new until the line has returned high.
- R9: `out_valid_o` and the fields stay unchanged while `out_ready_i` is 0. A cycle with `out_valid_o` and `out_ready_i` both high, and no frame completing, clears `out_valid_o` on the next edge.
- R10: If a frame completes in the same cycle as a handshake, the new frame is loaded and `out_valid_o` stays high.
- R11: If a frame completes while an earlier frame is still held and `out_ready_i` is 0, the new frame replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| wlen_i | input | 2 | Data length code (00=5 to 11=8 bits) |
| par_en_i | input | 1 | 1 = a parity bit follows the data |
| par_even_i | input | 1 | Parity type: 0 odd / forced 1, 1 even / forced 0 |
| par_force_i | input | 1 | 1 = parity bit is a fixed value |
| out_valid_o | output | 1 | A received frame is held |
| out_ready_i | input | 1 | Consumer accepts the held frame |
| out_data_o | output | 8 | Received data, zero-extended |
| par_err_o | output | 1 | Parity mismatch for the held frame |
| frm_err_o | output | 1 | Stop bit was 0 for the held frame |
| brk_o | output | 1 | Held frame was a break |

## Verification
Two events can fall on the same clock edge: a frame finishing, and the consumer accepting the previously held frame. The bench makes them coincide on purpose. It knows the tick on which the stop bit is sampled, so it holds one frame, sends a second, and raises `out_ready_i` only during that one tick's cycle. The result is judged at the ports. The old frame must still be visible the tick before, and afterwards `out_valid_o` must still be high and carry the second frame. A design that let the handshake win would show `out_valid_o` low instead.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_force;
  } rx_cfg_t;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/frx_parity.sv
module frx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              pbit_i,
  input  frx_pkg::rx_cfg_t  cfg_i,
  output logic              err_o
);
  logic ones_odd;
  logic expect_bit;

  always_comb begin
    ones_odd = ^data_i;
    if (cfg_i.par_force) expect_bit = ~cfg_i.par_even;
    else if (cfg_i.par_even) expect_bit = ones_odd;
    else expect_bit = ~ones_odd;
    err_o = cfg_i.par_en & (pbit_i != expect_bit);
  end
endmodule

// File: rtl/frx_core.sv
module frx_core #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  frx_pkg::rx_cfg_t  cfg_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pbit_o,
  output logic              stop_o,
  output logic              brk_o
);
  import frx_pkg::*;

  localparam int CNT_W      = $clog2(OSR);
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int START_LAST = OSR/2 - 2;
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_QUAL = CNT_W'(START_LAST);
  localparam logic [IDX_W-1:0] MIN_LAST = IDX_W'(4);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bidx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              all_zero;
  logic [IDX_W-1:0]  last_idx;
  logic              mid_bit;

  assign last_idx = MIN_LAST + IDX_W'(cfg_i.wlen);
  assign mid_bit  = (cnt == CNT_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      shreg    <= '0;
      pbit     <= 1'b0;
      all_zero <= 1'b1;
    end else if (tick_i) begin
      case (state)
        ST_IDLE: begin
          if (!rx_i) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (cnt == CNT_QUAL) begin
            cnt <= '0;
            if (rx_i) begin
              state <= ST_IDLE;
            end else begin
              state    <= ST_DATA;
              bidx     <= '0;
              shreg    <= '0;
              pbit     <= 1'b0;
              all_zero <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (mid_bit) begin
            cnt         <= '0;
            shreg[bidx] <= rx_i;
            if (rx_i) all_zero <= 1'b0;
            if (bidx == last_idx) state <= cfg_i.par_en ? ST_PAR : ST_STOP;
            else bidx <= bidx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (mid_bit) begin
            cnt   <= '0;
            pbit  <= rx_i;
            if (rx_i) all_zero <= 1'b0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (mid_bit) begin
            cnt   <= '0;
            state <= rx_i ? ST_IDLE : ST_WAITHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAITHI: begin
          if (rx_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_o = tick_i && (state == ST_STOP) && mid_bit;
  assign data_o = shreg;
  assign pbit_o = pbit;
  assign stop_o = rx_i;
  assign brk_o  = all_zero & ~rx_i;
endmodule

// File: rtl/frx_hold.sv
module frx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              brk_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              brk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      pe_o    <= 1'b0;
      fe_o    <= 1'b0;
      brk_o   <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      pe_o    <= pe_i;
      fe_o    <= fe_i;
      brk_o   <= brk_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [1:0]        wlen_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_force_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  frx_pkg::rx_cfg_t  cfg;
  logic              rx_sync;
  logic              frame_done;
  logic [DATA_W-1:0] core_data;
  logic              core_pbit;
  logic              core_stop;
  logic              core_brk;
  logic              core_pe;

  assign cfg = '{wlen: wlen_i, par_en: par_en_i, par_even: par_even_i,
                 par_force: par_force_i};

  frx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  frx_core #(.OSR(OSR), .DATA_W(DATA_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_sync),
    .tick_i(tick_i),
    .cfg_i (cfg),
    .done_o(frame_done),
    .data_o(core_data),
    .pbit_o(core_pbit),
    .stop_o(core_stop),
    .brk_o (core_brk)
  );

  frx_parity #(.DATA_W(DATA_W)) u_par (
    .data_i(core_data),
    .pbit_i(core_pbit),
    .cfg_i (cfg),
    .err_o (core_pe)
  );

  frx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_done),
    .data_i (core_data),
    .pe_i   (core_pe),
    .fe_i   (~core_stop),
    .brk_i  (core_brk),
    .ready_i(out_ready_i),
    .valid_o(out_valid_o),
    .data_o (out_data_o),
    .pe_o   (par_err_o),
    .fe_o   (frm_err_o),
    .brk_o  (brk_o)
  );
endmodule

// File: rtl/frx_sva.sv
module frx_sva #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_done,
  input logic [1:0]        wlen_i,
  input logic              par_en_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_data_o,
  input logic              par_err_o,
  input logic              frm_err_o,
  input logic              brk_o
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o); // R9

  AST_DRAIN_ON_HANDSHAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !frame_done |=> !out_valid_o); // R9

  AST_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !frame_done |=> $stable(out_data_o) && $stable(brk_o)); // R9

  AST_DONE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done |=> out_valid_o); // R10

  AST_BREAK_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && brk_o |-> frm_err_o && (out_data_o == '0)); // R8

  AST_SHORT_WORD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (wlen_i == 2'b00) |-> (out_data_o[DATA_W-1:5] == '0)); // R2

  AST_NO_PARITY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !par_en_i |-> !par_err_o); // R3
endmodule

bind frame_rx frx_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_done (frame_done),
  .wlen_i     (wlen_i),
  .par_en_i   (par_en_i),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .par_err_o  (par_err_o),
  .frm_err_o  (frm_err_o),
  .brk_o      (brk_o)
);

// File: tb/frame_rx_tb.sv
`timescale 1ns/100ps
module frame_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] wlen = 2'b11;
  logic       pen = 1'b0;
  logic       peven = 1'b0;
  logic       pforce = 1'b0;
  logic       ready_b = 1'b0;
  logic       coll_en = 1'b0;
  logic       ready;
  logic       valid;
  logic [7:0] dout;
  logic       pe, fe, brk;

  int chk_n = 0;
  int fail_n = 0;
  int tdiv = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 0);
  end

  assign ready = ready_b | (coll_en & tick);

  frame_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
    .wlen_i(wlen), .par_en_i(pen), .par_even_i(peven), .par_force_i(pforce),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(dout),
    .par_err_o(pe), .frm_err_o(fe), .brk_o(brk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chk_n++;
    if (!ok) begin
      fail_n++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (tick !== 1'b1) @(posedge clk);
    end
    #1;
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic want_pbit(input logic [7:0] d, input logic [1:0] wl,
                                     input logic even, input logic force_p);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (d[i] && mask_of(wl)[i]) ones++;
    if (force_p) return !even;
    if (even) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  // sends one frame with the current configuration; coll raises ready for
  // exactly the tick on which the stop bit is sampled
  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit stop_v,
                            input bit coll, input logic [7:0] prev);
    logic pb;
    pb = want_pbit(d, wlen, peven, pforce) ^ flip_par;
    rx = 1'b0; wait_tick(16);
    for (int i = 0; i < 5 + wlen; i++) begin
      rx = d[i]; wait_tick(16);
    end
    if (pen) begin rx = pb; wait_tick(16); end
    rx = stop_v;
    if (coll) begin
      wait_tick(7);
      check(valid === 1'b1 && dout === prev, "R10 old frame still held", dout, prev);
      coll_en = 1'b1;
      wait_tick(1);
      coll_en = 1'b0;
      wait_tick(8);
    end else begin
      wait_tick(16);
    end
    rx = 1'b1;
    wait_tick(4);
  endtask

  task automatic expect_frame(input logic [7:0] d, input bit e_pe, input bit e_fe,
                              input bit e_brk, input string req);
    check(valid === 1'b1, req, valid, 1);
    check(dout === (d & mask_of(wlen)), req, dout, d & mask_of(wlen));
    check(pe === e_pe, req, pe, e_pe);
    check(fe === e_fe, req, fe, e_fe);
    check(brk === e_brk, req, brk, e_brk);
  endtask

  task automatic consume();
    ready_b = 1'b1;
    @(posedge clk); #1;
    ready_b = 1'b0;
    check(valid === 1'b0, "R9 handshake clears valid", valid, 0);
  endtask

  initial begin : watchdog
    #750us;
    fail_n++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  end

  initial begin : stim
    logic [7:0] d, a, b;
    bit fp, st, brk_e;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1;
    check(valid === 1'b0 && dout === 8'h00 && pe === 1'b0 && fe === 1'b0 && brk === 1'b0,
          "R1 reset state", {valid, pe, fe, brk}, 0);
    rst_n = 1'b1;
    wait_tick(4);

    // R2 directed: each word length, no parity
    for (int w = 0; w < 4; w++) begin
      wlen = w[1:0]; pen = 1'b0;
      send_frame(8'hB5, 1'b0, 1'b1, 1'b0, 8'h00);
      expect_frame(8'hB5, 1'b0, 1'b0, 1'b0, "R2 word length");
      check(valid === 1'b1 && (dout & ~mask_of(wlen)) === 8'h00, "R2 upper bits zero", dout, 0);
      consume();
    end

    // R9 stall: held and stable across ticks
    wlen = 2'b11; pen = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b1, 1'b0, 8'h00);
    wait_tick(20);
    check(valid === 1'b1 && dout === 8'h3C, "R9 held while not ready", dout, 8'h3C);
    consume();

    // R6 false start: short low pulse
    rx = 1'b0; wait_tick(3); rx = 1'b1;
    wait_tick(40);
    check(valid === 1'b0, "R6 false start ignored", valid, 0);
    send_frame(8'hA7, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_frame(8'hA7, 1'b0, 1'b0, 1'b0, "R6 recovery after false start");
    consume();

    // R5 forced parity, both polarities, good and bad
    wlen = 2'b10; pen = 1'b1; pforce = 1'b1;
    for (int k = 0; k < 4; k++) begin
      peven = k[0];
      send_frame(8'h55, k[1], 1'b1, 1'b0, 8'h00);
      expect_frame(8'h55, k[1], 1'b0, 1'b0, "R5 forced parity");
      consume();
    end
    pforce = 1'b0;

    // R8 break, then no new frame while line stays low
    wlen = 2'b11; pen = 1'b1; peven = 1'b1;
    rx = 1'b0;
    wait_tick(16 * 11 + 40);
    expect_frame(8'h00, 1'b0, 1'b1, 1'b1, "R8 break detected");
    consume();
    wait_tick(64);
    check(valid === 1'b0, "R8 no start while line held low", valid, 0);
    rx = 1'b1; wait_tick(4);
    send_frame(8'h81, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_frame(8'h81, 1'b0, 1'b0, 1'b0, "R8 recovery after break");
    consume();

    // R11 overwrite while stalled
    wlen = 2'b11; pen = 1'b0;
    send_frame(8'h11, 1'b0, 1'b1, 1'b0, 8'h00);
    send_frame(8'h22, 1'b0, 1'b1, 1'b0, 8'h00);
    expect_frame(8'h22, 1'b0, 1'b0, 1'b0, "R11 newer frame replaces held");
    consume();

    // R10 load and handshake on the same edge
    a = 8'h6A; b = 8'hC3;
    send_frame(a, 1'b0, 1'b1, 1'b0, 8'h00);
    send_frame(b, 1'b0, 1'b1, 1'b1, a);
    expect_frame(b, 1'b0, 1'b0, 1'b0, "R10 completion beats handshake");
    consume();

    // constrained random: R3 R4 R5 R7 mixes
    for (int n = 0; n < 48; n++) begin
      d      = 8'($urandom);
      wlen   = 2'($urandom);
      pen    = 1'($urandom);
      peven  = 1'($urandom);
      pforce = ($urandom % 4) == 0;
      fp     = pen && (($urandom % 4) == 0);
      st     = ($urandom % 5) != 0;
      if (($urandom % 8) == 0) d = 8'h00;
      brk_e  = ((d & mask_of(wlen)) == 8'h00) && !st &&
               (!pen || ((want_pbit(d, wlen, peven, pforce) ^ fp) == 1'b0));
      send_frame(d, fp, st, 1'b0, 8'h00);
      if (!pen)
        expect_frame(d, 1'b0, !st, brk_e, "R3 no parity frame");
      else if (pforce)
        expect_frame(d, fp, !st, brk_e, "R5 forced parity random");
      else
        expect_frame(d, fp, !st, brk_e, "R4 odd/even parity and R7 stop check");
      consume();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    $finish;
  end
endmodule